// File: doc/BRIEF.md
# I2C Write-Path Slave for an 8-Bit GPIO Expander

This block is the serial front end of an 8-bit general-purpose I/O expander on an I2C bus. It oversamples SCL and SDA with a fast system clock and finds START and STOP conditions. It takes an address byte, and when the address matches and the transfer is a write, it acknowledges. The next byte is a command that selects one register as the destination for every data byte that follows, until the bus is released.

The slave address is a fixed four-bit prefix followed by three strap inputs, so up to eight expanders can share one bus. The port pins come straight from the output register. Each pin is enabled as a driver only while its configuration bit is clear. A data byte written to the output register appears on the pins just after the acknowledge clock of that byte.

Top module: `gpio_expander_slave`

## Requirements
- R1: After reset, `portOut` is 0xFF, `portOe` is 0x00 (every pin an input) and `sdaDrvLow` is 0.
- R2: An address byte of 0100 followed by `strapAddr[2:0]` (MSB first) with a write bit of 0 is acknowledged: `sdaDrvLow` is high during the ninth SCL high phase.
- R3: An address byte that does not match, or that matches but has the read bit (1), is not acknowledged. No later byte is acknowledged and no register changes until the next START.
- R4: While a transaction is selected, the command byte and every data byte are acknowledged in their ninth clock.
- R5: Command 0x01 routes the data bytes to the output register. `portOut` shows each byte once the SCL falling edge that ends that byte's acknowledge clock has been seen.
- R6: Command 0x03 routes the data bytes to the configuration register, and `portOe` equals the bitwise inverse of that register.
- R7: Command 0x02 routes the data bytes to the polarity register. This changes neither `portOut` nor `portOe`.
- R8: Command 0x00 (the read-only input register) and any command of 0x04 or above are acknowledged, but their data bytes change no register.
- R9: Any number of data bytes may follow one command. Every byte goes to the same register, and the last one written is held after STOP.
- R10: A repeated START in the middle of a byte discards the partial byte and restarts address reception. The interrupted transaction writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock as seen on the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| strapAddr | input | 3 | Low three bits of the slave address |
| sdaDrvLow | output | 1 | When 1, the pad pulls SDA low (acknowledge) |
| portOut | output | 8 | Output register value presented to the pins |
| portOe | output | 8 | Per-pin driver enable, 1 = pin drives `portOut` |

## Verification
A bad bit counter or a wrong state shows up on `sdaDrvLow` as a missing or misplaced acknowledge, in the same ninth clock as the fault. A wrong command pointer or a lost write strobe shows up on `portOut` or `portOe` within a few system clocks after the falling edge of that byte's acknowledge clock. The bench sweeps every strap value against every low address combination, every command from 0 to 7 and several prefix mismatches, and compares the acknowledges and pin state with a model computed in the bench.

// File: rtl/gpio_expander_pkg.sv
package gpio_expander_pkg;

  localparam int PORT_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_DATA,
    ST_SKIP
  } busState_t;

  // strobes from bus control to register datapath
  typedef struct packed {
    logic              wrStb;
    logic [7:0]        cmd;
    logic [PORT_W-1:0] data;
  } regStrobe_t;

endpackage

// File: rtl/gpio_expander_ctrl.sv
module gpio_expander_ctrl
  import gpio_expander_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_PREFIX = 4'b0100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  output logic       sdaDrvLow,
  output regStrobe_t strobe
);

  localparam int CNT_W   = 4;
  localparam int ACK_POS = 8;
  localparam int END_POS = 9;

  logic [SYNC_STAGES-1:0] sclChain, sdaChain;
  logic sclS, sdaS, sclPrev, sdaPrev;

  // synchroniser chains, idle bus value is high
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain[gi] <= 1'b1;
          sdaChain[gi] <= 1'b1;
        end else if (gi == 0) begin
          sclChain[gi] <= sclIn;
          sdaChain[gi] <= sdaIn;
        end else begin
          sclChain[gi] <= sclChain[gi-1];
          sdaChain[gi] <= sdaChain[gi-1];
        end
      end
    end
  endgenerate

  assign sclS = sclChain[SYNC_STAGES-1];
  assign sdaS = sdaChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  busState_t         state;
  logic [CNT_W-1:0]  bitCnt;
  logic [7:0]        shiftReg;
  logic [7:0]        cmdReg;
  logic              ackDrv;
  logic              wrStb;
  logic              addrHit;

  assign addrHit = (shiftReg[7:1] == {ADDR_PREFIX, strapAddr}) && !shiftReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      cmdReg   <= '0;
      ackDrv   <= 1'b0;
      wrStb    <= 1'b0;
    end else begin
      wrStb <= 1'b0;
      if (startDet) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        ackDrv <= 1'b0;
      end else if (stopDet) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
        ackDrv <= 1'b0;
      end else if (state != ST_IDLE && state != ST_SKIP) begin
        if (sclRise) begin
          if (bitCnt < CNT_W'(ACK_POS)) begin
            shiftReg <= {shiftReg[6:0], sdaS};
            bitCnt   <= bitCnt + 1'b1;
          end else if (bitCnt == CNT_W'(ACK_POS)) begin
            bitCnt <= CNT_W'(END_POS);
          end
        end else if (sclFall) begin
          if (bitCnt == CNT_W'(ACK_POS)) begin
            if (state == ST_ADDR && !addrHit) begin
              state  <= ST_SKIP;
              bitCnt <= '0;
            end else begin
              ackDrv <= 1'b1;
            end
          end else if (bitCnt == CNT_W'(END_POS)) begin
            ackDrv <= 1'b0;
            bitCnt <= '0;
            unique case (state)
              ST_ADDR: state <= ST_CMD;
              ST_CMD: begin
                cmdReg <= shiftReg;
                state  <= ST_DATA;
              end
              ST_DATA: wrStb <= 1'b1;
              default: state <= state;
            endcase
          end
        end
      end
    end
  end

  assign sdaDrvLow    = ackDrv;
  assign strobe.wrStb = wrStb;
  assign strobe.cmd   = cmdReg;
  assign strobe.data  = shiftReg;

  // R4: acknowledge only asserted while SCL is low
  a_r4_ack_rise_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrv) |-> !sclS);
  // R3: an unselected slave never pulls SDA
  a_r3_skip_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP || state == ST_IDLE) |-> !ackDrv);
  // R10: a START always restarts address reception
  a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && bitCnt == '0));
  // R9: write strobes only come from the data phase
  a_r9_strobe_in_data: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> state == ST_DATA);
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(END_POS));

endmodule

// File: rtl/gpio_expander_regs.sv
module gpio_expander_regs
  import gpio_expander_pkg::*;
#(
  parameter logic [PORT_W-1:0] OUT_RESET = '1,
  parameter logic [PORT_W-1:0] POL_RESET = '0,
  parameter logic [PORT_W-1:0] CFG_RESET = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  output logic [PORT_W-1:0] portOut,
  output logic [PORT_W-1:0] portOe
);

  localparam logic [7:0] CMD_OUT = 8'h01;
  localparam logic [7:0] CMD_POL = 8'h02;
  localparam logic [7:0] CMD_CFG = 8'h03;

  logic [PORT_W-1:0] outReg, polReg, cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= OUT_RESET;
      polReg <= POL_RESET;
      cfgReg <= CFG_RESET;
    end else if (strobe.wrStb) begin
      if (strobe.cmd == CMD_OUT) outReg <= strobe.data;
      if (strobe.cmd == CMD_POL) polReg <= strobe.data;
      if (strobe.cmd == CMD_CFG) cfgReg <= strobe.data;
    end
  end

  genvar pi;
  generate
    for (pi = 0; pi < PORT_W; pi++) begin : g_pin
      assign portOut[pi] = outReg[pi];
      assign portOe[pi]  = ~cfgReg[pi];
    end
  endgenerate

  // R8: without a strobe nothing moves
  a_r8_hold_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrStb |=> ($stable(outReg) && $stable(polReg) && $stable(cfgReg)));
  // R8: unmapped commands leave every register alone
  a_r8_bad_cmd_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStb && (strobe.cmd == 8'h00 || strobe.cmd > CMD_CFG))
      |=> ($stable(outReg) && $stable(polReg) && $stable(cfgReg)));
  // R7: a polarity write leaves the pins as they were
  a_r7_pol_no_pin: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStb && strobe.cmd == CMD_POL) |=> ($stable(portOut) && $stable(portOe)));
  // R5: an output write lands next cycle
  a_r5_out_written: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStb && strobe.cmd == CMD_OUT) |=> portOut == $past(strobe.data));

endmodule

// File: rtl/gpio_expander_slave.sv
module gpio_expander_slave
  import gpio_expander_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_PREFIX = 4'b0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        strapAddr,
  output logic              sdaDrvLow,
  output logic [PORT_W-1:0] portOut,
  output logic [PORT_W-1:0] portOe
);

  regStrobe_t strobe;

  gpio_expander_ctrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .ADDR_PREFIX (ADDR_PREFIX)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .strapAddr (strapAddr),
    .sdaDrvLow (sdaDrvLow),
    .strobe    (strobe)
  );

  gpio_expander_regs regs_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .portOut (portOut),
    .portOe  (portOe)
  );

endmodule

// File: tb/gpio_expander_slave_tb_top.sv
module gpio_expander_slave_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN;
  logic       mScl = 1'b1;
  logic       mSda = 1'b1;
  logic [2:0] strap = 3'd0;
  logic       sdaDrvLow;
  logic [7:0] portOut, portOe;
  logic       sdaLine;

  assign sdaLine = mSda & ~sdaDrvLow;

  gpio_expander_slave dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (mScl),
    .sdaIn     (sdaLine),
    .strapAddr (strap),
    .sdaDrvLow (sdaDrvLow),
    .portOut   (portOut),
    .portOe    (portOe)
  );

  localparam int Q = 6;
  int checks = 0;
  int errors = 0;
  logic [7:0] expOut = 8'hFF;
  logic [7:0] expCfg = 8'hFF;

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendBit(input logic b);
    mSda = b; waitQ();
    mScl = 1'b1; waitQ(); waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    ack = ~sdaLine;
    waitQ();
    mScl = 1'b0; waitQ(); waitQ();
  endtask

  task automatic checkPins(input string req);
    check(req, {24'd0, portOut}, {24'd0, expOut});
    check(req, {24'd0, portOe}, {24'd0, ~expCfg});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 portOut reset", {24'd0, portOut}, 32'hFF);
    check("R1 portOe reset", {24'd0, portOe}, 32'h00);
    check("R1 sda released", {31'd0, sdaDrvLow}, 32'd0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R2/R3 sweep: every strap against every low address combination
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int lo = 0; lo < 8; lo++) begin
        logic hit;
        logic [7:0] d;
        hit = (lo == s);
        d = {3'(s), 3'(lo), 2'b10};
        busStart();
        sendByte({4'b0100, 3'(lo), 1'b0}, ack);
        check(hit ? "R2 address ack" : "R3 mismatch no ack", {31'd0, ack}, {31'd0, hit});
        sendByte(8'h01, ack);
        check("R3/R4 command ack", {31'd0, ack}, {31'd0, hit});
        sendByte(d, ack);
        check("R3/R4 data ack", {31'd0, ack}, {31'd0, hit});
        busStop();
        if (hit) expOut = d;
        checkPins("R5 sweep pins");
      end
    end

    // R3: wrong fixed prefix never selects
    strap = 3'd0;
    for (int n = 0; n < 16; n++) begin
      if (n != 4) begin
        busStart();
        sendByte({4'(n), 3'd0, 1'b0}, ack);
        check("R3 prefix mismatch", {31'd0, ack}, 32'd0);
        sendByte(8'h01, ack);
        sendByte(8'h00, ack);
        check("R3 skipped data no ack", {31'd0, ack}, 32'd0);
        busStop();
        checkPins("R3 pins unchanged");
      end
    end

    // R3: read bit with matching address
    strap = 3'd5;
    busStart();
    sendByte({4'b0100, 3'd5, 1'b1}, ack);
    check("R3 read not acked", {31'd0, ack}, 32'd0);
    sendByte(8'h01, ack);
    sendByte(8'h11, ack);
    check("R3 read data no ack", {31'd0, ack}, 32'd0);
    busStop();
    checkPins("R3 read no write");

    // R6/R7/R8 command sweep
    for (int c = 0; c < 8; c++) begin
      logic [7:0] d;
      d = 8'h3C ^ 8'(c * 17);
      busStart();
      sendByte({4'b0100, 3'd5, 1'b0}, ack);
      sendByte(8'(c), ack);
      check("R8 command acked", {31'd0, ack}, 32'd1);
      sendByte(d, ack);
      check("R4 data acked", {31'd0, ack}, 32'd1);
      busStop();
      if (c == 1) expOut = d;
      if (c == 3) expCfg = d;
      checkPins(c == 3 ? "R6 config pins" : (c == 2 ? "R7 polarity no pin" : "R8 cmd pins"));
    end
    busStart();
    sendByte({4'b0100, 3'd5, 1'b0}, ack);
    sendByte(8'h81, ack);
    check("R8 high command acked", {31'd0, ack}, 32'd1);
    sendByte(8'h00, ack);
    busStop();
    checkPins("R8 high command ignored");

    // R9: stream of bytes to output register, R5 per-byte update
    busStart();
    sendByte({4'b0100, 3'd5, 1'b0}, ack);
    sendByte(8'h01, ack);
    for (int k = 0; k < 5; k++) begin
      logic [7:0] d;
      d = 8'(8'hA5 + k * 8'h13);
      sendByte(d, ack);
      check("R9 stream ack", {31'd0, ack}, 32'd1);
      expOut = d;
      check("R5 R9 per-byte update", {24'd0, portOut}, {24'd0, expOut});
    end
    busStop();
    checkPins("R9 last byte held");

    // R10: repeated START inside a data byte
    busStart();
    sendByte({4'b0100, 3'd5, 1'b0}, ack);
    sendByte(8'h01, ack);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    busStart();
    sendByte({4'b0100, 3'd5, 1'b0}, ack);
    check("R10 restart address ack", {31'd0, ack}, 32'd1);
    checkPins("R10 partial discarded");
    sendByte(8'h03, ack);
    sendByte(8'h0F, ack);
    expCfg = 8'h0F;
    busStop();
    checkPins("R10 new transaction");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule